// File: doc/BRIEF.md
# Dual-Modulus 128/129 and 64/65 Clock Prescaler

This block divides a fast input clock by one of four ratios: 128, 129, 64 or 65. Two inputs choose the ratio. `grp_sel` picks the ratio group and is meant to stay fixed while the divider runs. `mod_ctl` picks the base ratio (high) or the base ratio plus one (low), and a frequency synthesizer may change it from one division cycle to the next. The design has two parts. A front stage divides by four or five. A synchronous counter built from five toggle stages follows it. The counter advances only on the input edges where the front stage completes a pass, so it moves in step with the front stage and does not ripple.

The front stage is a finite state machine with five named phases: `FS_Q0`, `FS_Q1`, `FS_Q2`, `FS_Q3` and `FS_Q4`. The transitions are:

- Advance: `FS_Q0`→`FS_Q1`→`FS_Q2`→`FS_Q3`, one phase per input edge.
- Wrap: `FS_Q3`→`FS_Q0`, which closes a four-edge pass.
- Stretch: `FS_Q3`→`FS_Q4`, taken only when the extra edge is armed and the counter is in its last step.
- Return: `FS_Q4`→`FS_Q0`.

A pass completes on the edge that leaves `FS_Q3` by Wrap, or on the edge that leaves `FS_Q4`. On that edge the counter steps.

In the 64/65 group the counter's fourth stage is bypassed, so the counter has 16 steps instead of 32. The output is the counter's top stage. It goes high when the counter reaches its halfway step and drops when the counter wraps. The divider samples `mod_ctl` once per division cycle, on the edge where the counter enters its last step. That sample decides whether the front stage stretches that last step to five input edges.

Top module: `dual_mod_prescaler`

## Requirements
- R1: With `mod_ctl`=1 and `grp_sel`=0, consecutive falling edges of `div_out` are exactly 128 input rising edges apart.
- R2: With `mod_ctl`=0 and `grp_sel`=0, consecutive falling edges of `div_out` are exactly 129 input rising edges apart.
- R3: With `mod_ctl`=1 and `grp_sel`=1, the fourth counter stage is skipped and consecutive falling edges are exactly 64 input rising edges apart.
- R4: With `mod_ctl`=0 and `grp_sel`=1, consecutive falling edges are exactly 65 input rising edges apart.
- R5: `div_out` rises on input edge 64 of each division cycle in the 128/129 group, and on edge 32 in the 64/65 group. The low phase is therefore 64 or 32 edges, and the high phase is the rest of the cycle.
- R6: `div_out` falls only on the edge where the counter wraps from its terminal step to zero, which ends the division cycle. The counter never changes on an edge where the front stage does not complete a pass.
- R7: `mod_ctl` is sampled only on the input edge where the counter enters its last step. A change that arrives after that edge takes effect in the following division cycle. A change that arrives before it takes effect in the current cycle.
- R8: `rst` is synchronous and active high. While it is held, `div_out` is 0. The first division cycle after release has the full selected length, with its first rise on edge 64 (or 32) after release.
- R9: The front stage enters `FS_Q4` (divide by five) only during the counter's last step, and only when the sampled `mod_ctl` was 0. Every other pass takes four input edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to divide; the block acts on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mod_ctl | input | 1 | 1 selects the base ratio, 0 adds one input cycle |
| grp_sel | input | 1 | 0 selects the 128/129 group, 1 selects the 64/65 group (static) |
| div_out | output | 1 | Divided clock |

## Verification
The bench times falling-to-falling and rising-to-falling intervals in all four ratio settings. A design that added the fifth edge in the wrong step would still show the right period but a misplaced rise. A design that bypassed the wrong stage would show the wrong halfway point. The bench also changes `mod_ctl` one edge before and one edge after the sampling edge, in both directions. A divider that sampled continuously, or on the wrong edge, would stretch or shorten the wrong cycle. The first cycle after reset is measured from the release edge, which catches a reset that leaves a phase or a stale stretch request behind.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
    typedef enum logic [2:0] {
        FS_Q0 = 3'd0,
        FS_Q1 = 3'd1,
        FS_Q2 = 3'd2,
        FS_Q3 = 3'd3,
        FS_Q4 = 3'd4
    } front_phase_e;
endpackage

// File: rtl/dmp_front_fsm.sv
module dmp_front_fsm
    import dmp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic stretch_en,
    output logic carry
);
    front_phase_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= FS_Q0;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = FS_Q0;
        unique case (state_q)
            FS_Q0:   state_d = FS_Q1;
            FS_Q1:   state_d = FS_Q2;
            FS_Q2:   state_d = FS_Q3;
            FS_Q3:   state_d = stretch_en ? FS_Q4 : FS_Q0;
            FS_Q4:   state_d = FS_Q0;
            default: state_d = FS_Q0;
        endcase
    end

    // Pass completes on the edge that leaves FS_Q3 by Wrap, or leaves FS_Q4
    always_comb begin
        carry = 1'b0;
        unique case (state_q)
            FS_Q3:   carry = !stretch_en;
            FS_Q4:   carry = 1'b1;
            default: carry = 1'b0;
        endcase
    end

    // R9: the fifth phase is only reached when a stretch was requested
    assert_stretch_only_last_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && state_q == FS_Q4) |-> $past(stretch_en));
endmodule

// File: rtl/dmp_stage_counter.sv
module dmp_stage_counter #(
    parameter int STAGES     = 5,
    parameter int BYPASS_IDX = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              carry,
    input  logic              bypass,
    output logic [STAGES-1:0] cnt,
    output logic              at_last,
    output logic              near_last,
    output logic              hi_half
);
    localparam logic [STAGES-1:0] LSB_ONE = {{(STAGES-1){1'b0}}, 1'b1};

    logic [STAGES-1:0] q;
    logic [STAGES-1:0] live;
    logic [STAGES-1:0] ena;

    assign ena[0] = carry;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        localparam bit CAN_SKIP = (i == BYPASS_IDX);
        logic skip;
        assign skip    = CAN_SKIP && bypass;
        assign live[i] = !skip;
        if (i < STAGES - 1) begin : g_chain
            assign ena[i+1] = skip ? ena[i] : (ena[i] & q[i]);
        end
        always_ff @(posedge clk) begin
            if (rst)                q[i] <= 1'b0;
            else if (ena[i] && !skip) q[i] <= ~q[i];
        end
    end

    assign cnt       = q;
    assign at_last   = ((q & live) == live);
    assign near_last = ((q & live) == (live & ~LSB_ONE));
    assign hi_half   = q[STAGES-1];

    // R6: counter only moves when the front stage completes a pass
    assert_cnt_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(carry)) |-> $stable(q));

    // R6: a pass in the terminal step wraps every live stage to zero
    assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (at_last && carry && $stable(bypass)) |=> ((q & live) == '0));
endmodule

// File: rtl/dual_mod_prescaler.sv
module dual_mod_prescaler #(
    parameter int STAGES     = 5,
    parameter int BYPASS_IDX = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic mod_ctl,
    input  logic grp_sel,
    output logic div_out
);
    logic              carry;
    logic              stretch_en;
    logic              ext_q;
    logic [STAGES-1:0] cnt;
    logic              at_last;
    logic              near_last;
    logic              hi_half;
    logic              sample_now;

    dmp_front_fsm u_front (
        .clk        (clk),
        .rst        (rst),
        .stretch_en (stretch_en),
        .carry      (carry)
    );

    dmp_stage_counter #(
        .STAGES     (STAGES),
        .BYPASS_IDX (BYPASS_IDX)
    ) u_count (
        .clk       (clk),
        .rst       (rst),
        .carry     (carry),
        .bypass    (grp_sel),
        .cnt       (cnt),
        .at_last   (at_last),
        .near_last (near_last),
        .hi_half   (hi_half)
    );

    // Modulus request is captured as the counter steps into its last step
    assign sample_now = carry && near_last;

    always_ff @(posedge clk) begin
        if (rst)             ext_q <= 1'b0;
        else if (sample_now) ext_q <= ~mod_ctl;
    end

    assign stretch_en = ext_q && at_last;
    assign div_out    = hi_half;

    // R7: the captured request holds between sampling edges
    assert_ext_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(sample_now)) |-> $stable(ext_q));

    // R6: output falls only as the counter wraps
    assert_fall_at_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(div_out)) |-> ($past(at_last) && $past(carry) && (cnt == '0)));

    // R5: output rises only on a counter step
    assert_rise_on_step_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(div_out)) |-> $past(carry));
endmodule

// File: tb/test_dual_mod_prescaler.sv
module test_dual_mod_prescaler;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mod_ctl = 1'b1;
    logic grp_sel = 1'b0;
    logic div_out;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dual_mod_prescaler i_dual_mod_prescaler (
        .clk     (clk),
        .rst     (rst),
        .mod_ctl (mod_ctl),
        .grp_sel (grp_sel),
        .div_out (div_out)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input bit mc, input bit grp);
        @(negedge clk);
        rst = 1'b1;
        mod_ctl = mc;
        grp_sel = grp;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(div_out == 1'b0, "R8 output low in reset", int'(div_out), 0);
        rst = 1'b0;
    endtask

    // Period and phase measurement for one static setting
    task automatic run_mode(input bit mc, input bit grp, input int exp_n,
                            input int exp_h, input string tag);
        int edges = 0;
        int falls = 0;
        int last_fall = 0;
        int rise_e = -1;
        bit prev = 1'b0;
        do_reset(mc, grp);
        while (falls < 3 && edges < 1000) begin
            @(negedge clk);
            edges++;
            if (div_out && !prev) begin
                rise_e = edges;
                if (falls == 0)
                    check(rise_e == exp_n - exp_h, {tag, " R8 R5 first rise edge"},
                          rise_e, exp_n - exp_h);
            end
            if (!div_out && prev) begin
                check(edges - last_fall == exp_n, {tag, " period"}, edges - last_fall, exp_n);
                check(edges - rise_e == exp_h, {tag, " R5 R9 high phase"},
                      edges - rise_e, exp_h);
                last_fall = edges;
                falls++;
            end
            prev = div_out;
        end
        check(falls == 3, {tag, " falls seen"}, falls, 3);
    endtask

    // Change mod_ctl after edge `at` and time the next two cycles (R7)
    task automatic mid_switch(input bit grp, input bit mc0, input int at,
                              input int exp1, input int exp2, input string tag);
        int edges = 0;
        int falls = 0;
        int last_fall = 0;
        bit prev = 1'b0;
        do_reset(mc0, grp);
        while (falls < 2 && edges < 1000) begin
            @(negedge clk);
            edges++;
            if (edges == at) mod_ctl = ~mc0;
            if (!div_out && prev) begin
                check(edges - last_fall == (falls == 0 ? exp1 : exp2),
                      {tag, " R7 cycle length"}, edges - last_fall,
                      (falls == 0 ? exp1 : exp2));
                last_fall = edges;
                falls++;
            end
            prev = div_out;
        end
        check(falls == 2, {tag, " R7 falls seen"}, falls, 2);
    endtask

    initial begin
        run_mode(1'b1, 1'b0, 128, 64, "R1 div128");
        run_mode(1'b0, 1'b0, 129, 65, "R2 div129");
        run_mode(1'b1, 1'b1, 64, 32, "R3 div64");
        run_mode(1'b0, 1'b1, 65, 33, "R4 div65");
        // last step entered on edge 124 (group 128) or 60 (group 64)
        mid_switch(1'b0, 1'b1, 125, 128, 129, "R7 late drop g128");
        mid_switch(1'b0, 1'b1, 123, 129, 129, "R7 early drop g128");
        mid_switch(1'b1, 1'b1, 61, 64, 65, "R7 late drop g64");
        mid_switch(1'b1, 1'b0, 59, 64, 64, "R7 early raise g64");
        mid_switch(1'b0, 1'b0, 125, 129, 128, "R7 late raise g128");
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule